// File: doc/BRIEF.md
# Golomb Run-Length Bitstream Encoder

The block turns a serial stream of binary symbols into Golomb code. It counts the zeros that precede each one in the input, and the count of each such run is the value to code. The divisor `M` is fixed at elaboration. Every run length N is split into a quotient `N / M`, sent in unary form, and a remainder `N % M`, sent in binary. When `M` is not a power of two the remainder uses truncated binary, so the small remainders save one bit. Code bits leave the block one per cycle.

Both stream edges use valid/ready. An input beat is taken in any cycle where `in_valid` and `in_ready` are both high. An output bit is taken in any cycle where `out_valid` and `out_ready` are both high. The block holds one codeword at a time. While that codeword is being sent, `in_ready` stays low, so back-pressure at the output reaches the input. `in_last` marks the final beat of a data set. If that beat is a zero, the run still open is closed as if a one had followed it. `run_overflow` is a plain status pulse. The run counter saturates at `MAX_RUN = (15 - B) * M + M - 1`, where `B = ceil(log2 M)`, and with that limit no codeword is longer than 16 bits.

Top module: `gre_encoder`

## Requirements
- R1: During and straight after reset, `out_valid` and `run_overflow` are 0 and `in_ready` is 1.
- R2: A codeword begins with q = floor(N/M) zero bits and then one stop bit of value 1. N is the number of zeros accepted since the previous run ended.
- R3: When M is a power of two, B = log2(M) remainder bits follow the stop bit, and they send N mod M most significant bit first.
- R4: When M is not a power of two, let T = 2^B - M with B = ceil(log2 M). A remainder r < T is sent in B-1 bits as r. Any other remainder is sent in B bits as r + T. Both forms are sent MSB first.
- R5: Only an accepted one ends a run and starts a codeword, and the zero count then restarts from 0. A zero adds to the count and produces no output.
- R6: An accepted zero with `in_last` = 1 closes the run with that zero included, as if a one followed it. An accepted one with `in_last` = 1 is coded normally and adds nothing extra.
- R7: The first code bit is valid in the cycle after the terminating beat is accepted. `in_ready` is 0 from then until the handshake of the last code bit, and it is 1 again in the next cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_bit` keeps its value into the next cycle.
- R9: A zero accepted while the count already equals MAX_RUN leaves the count at MAX_RUN. `run_overflow` pulses 1 in the following cycle. No codeword exceeds 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_bit | input | 1 | Input symbol |
| in_valid | input | 1 | Input beat present |
| in_last | input | 1 | Beat is the last of the data set |
| in_ready | output | 1 | Block can take an input beat |
| out_bit | output | 1 | Code bit |
| out_valid | output | 1 | Code bit present |
| out_ready | input | 1 | Sink takes the code bit |
| run_overflow | output | 1 | One-cycle pulse: a zero arrived with the run counter saturated |

## Verification
The bench builds three encoders side by side, with M = 2 (the default), M = 3 and M = 8, and feeds all three the same symbol stream. M = 3 is the only build that exercises truncated remainders: its remainder 0 takes one bit, and its remainders 1 and 2 take two bits. M = 8 gives long unary prefixes and the three-bit remainder, including the run of 61. The three builds saturate at different limits (29, 41 and 103), so one long run of zeros reaches each saturation point and the overflow pulse of each one.

// File: rtl/gre_pkg.sv
package gre_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_UNARY = 2'd1,
    PH_STOP  = 2'd2,
    PH_REM   = 2'd3
  } gre_phase_e;
endpackage

// File: rtl/gre_run_counter.sv
module gre_run_counter #(
  parameter int MAX_RUN = 29,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             sym,
  input  logic             last,
  output logic             run_done,
  output logic [CNT_W-1:0] run_len,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic             at_max;

  assign at_max   = (cnt == CNT_W'(MAX_RUN));
  assign cnt_inc  = at_max ? cnt : cnt + 1'b1;
  assign run_done = accept & (sym | last);
  // a zero that closes the data set counts toward its own run
  assign run_len  = sym ? cnt : cnt_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= accept & ~sym & at_max;
      if (accept) begin
        if (run_done) cnt <= '0;
        else          cnt <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/gre_code_map.sv
module gre_code_map #(
  parameter int M     = 2,
  parameter int CNT_W = 5,
  parameter int Q_W   = 4,
  parameter int R_W   = 1,
  parameter int LEN_W = 1
) (
  input  logic [CNT_W-1:0] run_len,
  output logic [Q_W-1:0]   quot,
  output logic [R_W-1:0]   rem_val,
  output logic [LEN_W-1:0] rem_len
);
  localparam int  B       = $clog2(M);
  localparam bit  IS_POW2 = ((M & (M - 1)) == 0);
  localparam int  THR     = (1 << B) - M;

  logic [CNT_W-1:0] rem_full;

  assign quot     = Q_W'(run_len / CNT_W'(M));
  assign rem_full = run_len % CNT_W'(M);

  generate
    if (IS_POW2) begin : g_plain
      assign rem_val = R_W'(rem_full);
      assign rem_len = LEN_W'(B);
    end else begin : g_trunc
      always_comb begin
        if (rem_full < CNT_W'(THR)) begin
          rem_val = R_W'(rem_full);
          rem_len = LEN_W'(B - 1);
        end else begin
          rem_val = R_W'(rem_full + CNT_W'(THR));
          rem_len = LEN_W'(B);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gre_serializer.sv
module gre_serializer
  import gre_pkg::*;
#(
  parameter int Q_W   = 4,
  parameter int R_W   = 1,
  parameter int LEN_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [Q_W-1:0]   quot,
  input  logic [R_W-1:0]   rem_val,
  input  logic [LEN_W-1:0] rem_len,
  input  logic             out_ready,
  output logic             busy,
  output logic             out_bit
);
  gre_phase_e       phase;
  logic [Q_W-1:0]   q_left;
  logic [R_W-1:0]   rem_sr;
  logic [LEN_W-1:0] rem_left;

  assign busy = (phase != PH_IDLE);

  always_comb begin
    case (phase)
      PH_STOP: out_bit = 1'b1;
      PH_REM:  out_bit = rem_sr[R_W-1];
      default: out_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      q_left   <= '0;
      rem_sr   <= '0;
      rem_left <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (load) begin
            q_left   <= quot;
            rem_sr   <= rem_val << (LEN_W'(R_W) - rem_len);
            rem_left <= rem_len;
            phase    <= (quot != '0) ? PH_UNARY : PH_STOP;
          end
        end
        PH_UNARY: begin
          if (out_ready) begin
            q_left <= q_left - 1'b1;
            if (q_left == Q_W'(1)) phase <= PH_STOP;
          end
        end
        PH_STOP: begin
          if (out_ready) phase <= (rem_left == '0) ? PH_IDLE : PH_REM;
        end
        PH_REM: begin
          if (out_ready) begin
            rem_sr   <= rem_sr << 1;
            rem_left <= rem_left - 1'b1;
            if (rem_left == LEN_W'(1)) phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gre_encoder.sv
module gre_encoder #(
  parameter int M      = 2,
  parameter int CW_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bit,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic out_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic run_overflow
);
  localparam int B       = $clog2(M);
  localparam int R_W     = (B < 1) ? 1 : B;
  localparam int LEN_W   = $clog2(R_W + 1);
  localparam int QMAX    = CW_MAX - 1 - B;
  localparam int Q_W     = $clog2(QMAX + 1);
  localparam int MAX_RUN = QMAX * M + M - 1;
  localparam int CNT_W   = $clog2(MAX_RUN + 1);

  logic             accept;
  logic             run_done;
  logic [CNT_W-1:0] run_len;
  logic [Q_W-1:0]   quot;
  logic [R_W-1:0]   rem_val;
  logic [LEN_W-1:0] rem_len;
  logic             busy;

  assign in_ready  = ~busy;
  assign out_valid = busy;
  assign accept    = in_valid & in_ready;

  gre_run_counter #(.MAX_RUN(MAX_RUN), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .sym      (in_bit),
    .last     (in_last),
    .run_done (run_done),
    .run_len  (run_len),
    .ovf      (run_overflow)
  );

  gre_code_map #(.M(M), .CNT_W(CNT_W), .Q_W(Q_W), .R_W(R_W), .LEN_W(LEN_W)) u_map (
    .run_len (run_len),
    .quot    (quot),
    .rem_val (rem_val),
    .rem_len (rem_len)
  );

  gre_serializer #(.Q_W(Q_W), .R_W(R_W), .LEN_W(LEN_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (run_done),
    .quot      (quot),
    .rem_val   (rem_val),
    .rem_len   (rem_len),
    .out_ready (out_ready),
    .busy      (busy),
    .out_bit   (out_bit)
  );
endmodule

// File: rtl/gre_encoder_chk.sv
module gre_encoder_chk #(
  parameter int CW_MAX = 16
) (
  input logic clk,
  input logic rst_n,
  input logic in_bit,
  input logic in_valid,
  input logic in_last,
  input logic in_ready,
  input logic out_bit,
  input logic out_valid,
  input logic out_ready,
  input logic run_overflow
);
  logic [5:0] cw_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cw_cnt <= '0;
    else if (in_ready)               cw_cnt <= '0;
    else if (out_valid && out_ready) cw_cnt <= cw_cnt + 1'b1;
  end

  // R1: idle state right after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (in_ready && !out_valid && !run_overflow));

  // R7: a terminating one yields a code bit next cycle
  assert_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_bit || in_last)) |=> out_valid);

  // R7: input reopens once the codeword is gone
  assert_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> in_ready);

  // R8: held bit under back-pressure
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R9: overflow only follows an accepted zero
  assert_ovf_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_overflow |-> $past(in_valid && in_ready && !in_bit));

  // R9: codeword length bound
  assert_cw_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cw_cnt <= 6'(CW_MAX));
endmodule

bind gre_encoder gre_encoder_chk #(.CW_MAX(CW_MAX)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_bit       (in_bit),
  .in_valid     (in_valid),
  .in_last      (in_last),
  .in_ready     (in_ready),
  .out_bit      (out_bit),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .run_overflow (run_overflow)
);

// File: tb/gre_encoder_tb.sv
module gre_encoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDUT       = 3;
  localparam int MS [NDUT]  = '{2, 3, 8};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv_bit = 1'b0, drv_valid = 1'b0, drv_last = 1'b0;
  logic out_ready = 1'b1;
  logic [NDUT-1:0] in_ready_v, out_valid_v, out_bit_v, ovf_v;
  logic all_ready, in_valid_g;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 1'b0;

  int        cnt      [NDUT];
  int        exp_len  [NDUT];
  logic [15:0] exp_bits [NDUT];
  int        exp_tag  [NDUT][16];
  bit        ovf_pend [NDUT];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign all_ready  = &in_ready_v;
  assign in_valid_g = drv_valid & all_ready;

  gre_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_bit(drv_bit), .in_valid(in_valid_g), .in_last(drv_last),
    .in_ready(in_ready_v[0]), .out_bit(out_bit_v[0]), .out_valid(out_valid_v[0]),
    .out_ready(out_ready), .run_overflow(ovf_v[0]));

  gre_encoder #(.M(3)) u_dut_m3 (
    .clk(clk), .rst_n(rst_n), .in_bit(drv_bit), .in_valid(in_valid_g), .in_last(drv_last),
    .in_ready(in_ready_v[1]), .out_bit(out_bit_v[1]), .out_valid(out_valid_v[1]),
    .out_ready(out_ready), .run_overflow(ovf_v[1]));

  gre_encoder #(.M(8)) u_dut_m8 (
    .clk(clk), .rst_n(rst_n), .in_bit(drv_bit), .in_valid(in_valid_g), .in_last(drv_last),
    .in_ready(in_ready_v[2]), .out_bit(out_bit_v[2]), .out_valid(out_valid_v[2]),
    .out_ready(out_ready), .run_overflow(ovf_v[2]));

  function automatic int ceil_log2(input int v);
    int b = 0;
    while ((1 << b) < v) b++;
    return b;
  endfunction

  function automatic int max_run(input int m);
    return (15 - ceil_log2(m)) * m + m - 1;
  endfunction

  task automatic push(input int i, input logic b, input int tag);
    exp_bits[i] = {exp_bits[i][14:0], b};
    for (int k = 15; k > 0; k--) exp_tag[i][k] = exp_tag[i][k-1];
    exp_tag[i][0] = tag;
    exp_len[i]++;
  endtask

  // reference codeword, built from the requirement text
  task automatic emit(input int i, input int n);
    int m = MS[i];
    int b = ceil_log2(m);
    int q = n / m;
    int r = n % m;
    int rtag = ((m & (m - 1)) == 0) ? 3 : 4;
    int val, len, t;
    exp_bits[i] = '0;
    exp_len[i] = 0;
    for (int k = 0; k < q; k++) push(i, 1'b0, 2);
    push(i, 1'b1, 2);
    t = (1 << b) - m;
    if (rtag == 3)  begin val = r;     len = b;     end
    else if (r < t) begin val = r;     len = b - 1; end
    else            begin val = r + t; len = b;     end
    for (int k = len - 1; k >= 0; k--) push(i, val[k], rtag);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int dut, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s dut%0d %s actual=%0d expected=%0d", req, dut, what, act, expv);
    end
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      for (int i = 0; i < NDUT; i++) begin
        check(out_valid_v[i] == (exp_len[i] > 0), "R5", "out_valid", i,
              out_valid_v[i], exp_len[i] > 0);
        check(in_ready_v[i] == (exp_len[i] == 0), "R7", "in_ready", i,
              in_ready_v[i], exp_len[i] == 0);
        if (exp_len[i] > 0)
          check(out_bit_v[i] == exp_bits[i][exp_len[i]-1],
                (exp_tag[i][exp_len[i]-1] == 2) ? "R2" :
                (exp_tag[i][exp_len[i]-1] == 3) ? "R3" : "R4",
                out_ready ? "out_bit" : "out_bit R8", i,
                out_bit_v[i], exp_bits[i][exp_len[i]-1]);
        check(ovf_v[i] == ovf_pend[i], "R9", "run_overflow", i, ovf_v[i], ovf_pend[i]);
        ovf_pend[i] = 1'b0;
      end
      for (int i = 0; i < NDUT; i++) begin
        if (exp_len[i] > 0 && out_ready) exp_len[i]--;
        else if (drv_valid && all_ready) begin
          if (drv_bit) begin
            emit(i, cnt[i]);
            cnt[i] = 0;
          end else begin
            if (cnt[i] == max_run(MS[i])) ovf_pend[i] = 1'b1;
            else cnt[i]++;
            if (drv_last) begin
              emit(i, cnt[i]);   // R6: closing zero
              cnt[i] = 0;
            end
          end
        end
      end
    end
  end

  task automatic send(input logic b, input logic l);
    @(negedge clk);
    drv_bit = b; drv_last = l; drv_valid = 1'b1;
    #1;
    while (!all_ready) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic send_run(input int zeros);
    for (int k = 0; k < zeros; k++) send(1'b0, 1'b0);
    send(1'b1, 1'b0);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    drv_valid = 1'b0; drv_last = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : sink
    @(posedge rst_n);
    repeat (30) @(negedge clk);
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 9) < 7);
    end
  end

  initial begin : stim
    for (int i = 0; i < NDUT; i++) begin
      cnt[i] = 0; exp_len[i] = 0; exp_bits[i] = '0; ovf_pend[i] = 1'b0;
      for (int k = 0; k < 16; k++) exp_tag[i][k] = 0;
    end
    repeat (2) @(negedge clk);
    // R1: reset values
    for (int i = 0; i < NDUT; i++) begin
      check(in_ready_v[i] == 1'b1, "R1", "in_ready in reset", i, in_ready_v[i], 1);
      check(out_valid_v[i] == 1'b0, "R1", "out_valid in reset", i, out_valid_v[i], 0);
      check(ovf_v[i] == 1'b0, "R1", "run_overflow in reset", i, ovf_v[i], 0);
    end
    rst_n = 1'b1;
    // R5: immediate one gives N = 0
    send_run(0);
    send_run(61);   // R3 with M=8: 00000001101
    send_run(5);
    send_run(15);
    send_run(1);
    send_run(2);    // R4 with M=3: remainder 2 in two bits
    send_run(3);
    send_run(7);
    idle(25);
    // R9: run longer than every saturation limit
    send_run(110);
    // pseudo-random symbols
    for (int k = 0; k < 200; k++) send(($urandom_range(0, 3) == 0), 1'b0);
    send(1'b1, 1'b0);
    // R6: data set ending on zeros
    send(1'b0, 1'b0);
    send(1'b0, 1'b0);
    send(1'b0, 1'b1);
    // R6: data set ending on a one
    send(1'b0, 1'b0);
    send(1'b1, 1'b1);
    // R6: a lone closing zero
    send(1'b0, 1'b1);
    idle(60);
    for (int i = 0; i < NDUT; i++)
      check(in_ready_v[i] == 1'b1 && out_valid_v[i] == 1'b0, "R7", "drained", i,
            {in_ready_v[i], out_valid_v[i]}, 2);
    finish_run();
  end
endmodule